// File: doc/BRIEF.md
# Conversion Mode and Calibration Sequencer

This block sequences the operating mode of a sigma-delta converter core. A host writes a 3-bit mode field together with a 4-bit output-rate code. A separate strobe reports a write to the configuration or I/O settings, or a change of input channel. The filter sends a tick each time it finishes a conversion period. From these inputs the sequencer drives several outputs:

- the modulator/filter reset and power-down controls;
- the ready and error status bits;
- a strobe that stores each conversion result;
- write strobes that load calibration coefficients into the offset and full-scale registers of the channel being calibrated.

After any restart, the first result is thrown away: a new result appears only on the second tick. A calibration counts a number of ticks that depends on the gain code and the reference choice. When it finishes it stores its coefficient and drops the converter into idle. The host's own writes to the coefficient registers are let through only while the converter is idle or powered down.

Top module: `conv_mode_seq`

## Requirements
- R1: After reset: mode_out is 0 (continuous), rdy is 1, err is 0, rate_sel holds the default code 4'b1010, and pwr_dn, mod_rst and every strobe are 0.
- R2: Mode codes are 0 continuous, 1 single, 2 idle, 3 power-down, 4 internal zero-scale cal, 5 internal full-scale cal, 6 system offset cal and 7 system full-scale cal. A mode write with rate code 0 is ignored. An accepted write updates mode_out and rate_sel on the next edge, sets rdy, and raises mod_rst for exactly one cycle.
- R3: cfg_wr sets rdy, raises mod_rst for one cycle and restarts the count, so the next result needs two ticks.
- R4: In continuous mode the first result (result_we pulse) comes on the second tick after a restart, and later results come on every tick. Each result drives rdy low, and data_rd drives it high again.
- R5: In single mode one result comes on the second tick. pwr_dn then goes high, further ticks produce no result, and rdy stays low until data_rd.
- R6: In idle, mod_rst is held high and ticks produce nothing. In power-down, pwr_dn and rdy are both high.
- R7: err takes clamp_in at each result. An accepted write of a converting mode (0, 1, 4, 5, 6, 7) clears it. A rejected write leaves it unchanged.
- R8: Calibration lengths are 2 ticks for modes 4, 6 and 7. Mode 5 takes 2 ticks at gain code 0 (gain 1) with the external reference (ref_int 0), and 4 ticks at gain codes 1..6 (gain is 2 to the power of the code). rdy is high during a calibration. At the final tick, modes 4 and 6 pulse cal_off_wr and modes 5 and 7 pulse cal_fs_wr, with rdy going low and mode_out becoming 2.
- R9: Mode 5 at gain code 0 with ref_int 1 pulses cal_fs_wr and fs_factory on the edge after the write, with mode_out 2 and rdy 0, and uses no ticks.
- R10: Mode 5 at gain code 7 (gain 128) leaves mode_out unchanged and sets rdy.
- R11: host_off_we and host_fs_we follow host_off_wr and host_fs_wr only while mode_out is 2 or 3, and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_in | input | 3 | Mode code carried by the write |
| rate_in | input | 4 | Output-rate code carried by the write |
| cfg_wr | input | 1 | Configuration/IO write or channel change |
| gain_in | input | 3 | Gain code (gain = 2^code) |
| ref_int | input | 1 | 1 selects the internal reference |
| conv_tick | input | 1 | Conversion period completed by the filter |
| clamp_in | input | 1 | Current result was clamped |
| data_rd | input | 1 | Data register read |
| host_off_wr | input | 1 | Host write to an offset register |
| host_fs_wr | input | 1 | Host write to a full-scale register |
| mode_out | output | 3 | Current mode |
| rate_sel | output | 4 | Current rate code |
| rdy | output | 1 | Ready flag, 0 = result available |
| err | output | 1 | Result clamped flag |
| result_we | output | 1 | Store conversion result |
| cal_off_wr | output | 1 | Store offset coefficient from calibration |
| cal_fs_wr | output | 1 | Store full-scale coefficient from calibration |
| fs_factory | output | 1 | Full-scale store takes the factory value |
| mod_rst | output | 1 | Modulator and filter reset |
| pwr_dn | output | 1 | Converter power-down |
| host_off_we | output | 1 | Gated host offset write |
| host_fs_we | output | 1 | Gated host full-scale write |

## Verification
The bench walks a table of calibration cases covering every calibration mode, both references and gain codes 0, 3, 5 and 7. For each case it counts the ticks until the coefficient strobe. A design with a wrong length table would strobe early or late, and one that confused the offset and full-scale targets would raise the wrong strobe. Directed tests then go after the discarded first result: a design that skips it would report a result on the very first tick after a restart or a cfg_wr. They also check single-mode results that repeat after the first, an error flag that a rejected write clears, a gain-128 full-scale calibration that slips through, and host coefficient writes that leak in active modes.

// File: rtl/cms_pkg.sv
package cms_pkg;
    typedef enum logic [2:0] {
        MD_CONT     = 3'd0,
        MD_SINGLE   = 3'd1,
        MD_IDLE     = 3'd2,
        MD_PDOWN    = 3'd3,
        MD_ZS_CAL   = 3'd4,
        MD_FS_CAL   = 3'd5,
        MD_SOFF_CAL = 3'd6,
        MD_SFS_CAL  = 3'd7
    } mode_e;

    function automatic logic is_cal(input mode_e m);
        return m[2];
    endfunction

    function automatic logic starts_conv(input mode_e m);
        return (m == MD_CONT) || (m == MD_SINGLE) || m[2];
    endfunction
endpackage

// File: rtl/seq_len_sel.sv
module seq_len_sel
    import cms_pkg::*;
#(
    parameter int GAIN_W      = 3,
    parameter int CNT_W       = 3,
    parameter int SHORT_TICKS = 2,
    parameter int LONG_TICKS  = 4
) (
    input  mode_e              mode,
    input  logic [GAIN_W-1:0]  gain,
    input  logic               ref_int,
    output logic [CNT_W-1:0]   need,
    output logic               cal_legal,
    output logic               factory
);
    localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
    localparam logic [CNT_W-1:0]  N_SHORT  = CNT_W'(SHORT_TICKS);
    localparam logic [CNT_W-1:0]  N_LONG   = CNT_W'(LONG_TICKS);

    logic unity;
    assign unity = (gain == '0);

    always_comb begin
        need      = N_SHORT;
        cal_legal = 1'b1;
        factory   = 1'b0;
        if (mode == MD_FS_CAL) begin
            cal_legal = (gain != GAIN_MAX);
            factory   = unity && ref_int;
            need      = unity ? N_SHORT : N_LONG;
        end
    end
endmodule

// File: rtl/seq_coef_gate.sv
module seq_coef_gate
    import cms_pkg::*;
#(
    parameter int NUM_COEF = 2
) (
    input  mode_e               mode,
    input  logic [NUM_COEF-1:0] host_wr,
    output logic [NUM_COEF-1:0] host_we
);
    logic quiet;
    assign quiet = (mode == MD_IDLE) || (mode == MD_PDOWN);

    for (genvar i = 0; i < NUM_COEF; i++) begin : g_gate
        assign host_we[i] = host_wr[i] && quiet;
    end
endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
    import cms_pkg::*;
#(
    parameter int              RATE_W      = 4,
    parameter int              GAIN_W      = 3,
    parameter int              CNT_W       = 3,
    parameter int              SHORT_TICKS = 2,
    parameter int              LONG_TICKS  = 4,
    parameter logic [RATE_W-1:0] RATE_RST  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_in,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              cfg_wr,
    input  logic [GAIN_W-1:0] gain_in,
    input  logic              ref_int,
    input  logic              conv_tick,
    input  logic              clamp_in,
    input  logic              data_rd,
    input  logic              host_off_wr,
    input  logic              host_fs_wr,
    output logic [2:0]        mode_out,
    output logic [RATE_W-1:0] rate_sel,
    output logic              rdy,
    output logic              err,
    output logic              result_we,
    output logic              cal_off_wr,
    output logic              cal_fs_wr,
    output logic              fs_factory,
    output logic              mod_rst,
    output logic              pwr_dn,
    output logic              host_off_we,
    output logic              host_fs_we
);
    localparam logic [CNT_W-1:0] N_FIRST = CNT_W'(SHORT_TICKS);

    typedef struct packed {
        mode_e             mode;
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  need;
        logic              rdy;
        logic              err;
        logic              sgl_done;
        logic              restart;
        logic              res_we;
        logic              off_wr;
        logic              fs_wr;
        logic              fact;
    } seq_t;

    seq_t s_d, s_q;

    mode_e            new_mode;
    logic [CNT_W-1:0] need_w;
    logic             cal_legal_w, factory_w;
    logic             active, last_tick, result_now;
    logic [1:0]       host_we_w;

    assign new_mode = mode_e'(mode_in);

    seq_len_sel #(
        .GAIN_W(GAIN_W), .CNT_W(CNT_W),
        .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
    ) u_len (
        .mode(new_mode), .gain(gain_in), .ref_int(ref_int),
        .need(need_w), .cal_legal(cal_legal_w), .factory(factory_w)
    );

    seq_coef_gate #(.NUM_COEF(2)) u_gate (
        .mode(s_q.mode), .host_wr({host_fs_wr, host_off_wr}), .host_we(host_we_w)
    );

    always_comb begin
        active = (s_q.mode == MD_CONT) || is_cal(s_q.mode) ||
                 ((s_q.mode == MD_SINGLE) && !s_q.sgl_done);
        last_tick  = ({1'b0, s_q.cnt} + 1'b1) >= {1'b0, s_q.need};
        result_now = 1'b0;

        s_d         = s_q;
        s_d.restart = 1'b0;
        s_d.res_we  = 1'b0;
        s_d.off_wr  = 1'b0;
        s_d.fs_wr   = 1'b0;
        s_d.fact    = 1'b0;

        if (mode_wr && (rate_in != '0)) begin
            s_d.rdy     = 1'b1;
            s_d.restart = 1'b1;
            s_d.cnt     = '0;
            if ((new_mode != MD_FS_CAL) || cal_legal_w) begin
                s_d.mode     = new_mode;
                s_d.rate     = rate_in;
                s_d.need     = need_w;
                s_d.sgl_done = 1'b0;
                if (starts_conv(new_mode)) s_d.err = 1'b0;
                if ((new_mode == MD_FS_CAL) && factory_w) begin
                    s_d.mode  = MD_IDLE;
                    s_d.rdy   = 1'b0;
                    s_d.fs_wr = 1'b1;
                    s_d.fact  = 1'b1;
                end
            end
        end else if (cfg_wr) begin
            s_d.rdy     = 1'b1;
            s_d.restart = 1'b1;
            s_d.cnt     = '0;
        end else begin
            if (conv_tick && active) begin
                if (s_q.cnt < s_q.need) s_d.cnt = s_q.cnt + 1'b1;
                if (last_tick) begin
                    result_now = 1'b1;
                    s_d.rdy    = 1'b0;
                    unique case (s_q.mode)
                        MD_CONT: begin
                            s_d.res_we = 1'b1;
                            s_d.err    = clamp_in;
                        end
                        MD_SINGLE: begin
                            s_d.res_we   = 1'b1;
                            s_d.err      = clamp_in;
                            s_d.sgl_done = 1'b1;
                        end
                        MD_ZS_CAL, MD_SOFF_CAL: begin
                            s_d.off_wr = 1'b1;
                            s_d.mode   = MD_IDLE;
                        end
                        default: begin
                            s_d.fs_wr = 1'b1;
                            s_d.mode  = MD_IDLE;
                        end
                    endcase
                end
            end
            if (data_rd && !result_now) s_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.mode     <= MD_CONT;
            s_q.rate     <= RATE_RST;
            s_q.need     <= N_FIRST;
            s_q.rdy      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_out    = s_q.mode;
    assign rate_sel    = s_q.rate;
    assign rdy         = s_q.rdy;
    assign err         = s_q.err;
    assign result_we   = s_q.res_we;
    assign cal_off_wr  = s_q.off_wr;
    assign cal_fs_wr   = s_q.fs_wr;
    assign fs_factory  = s_q.fact;
    assign pwr_dn      = (s_q.mode == MD_PDOWN) || ((s_q.mode == MD_SINGLE) && s_q.sgl_done);
    assign mod_rst     = s_q.restart || (s_q.mode == MD_IDLE) || pwr_dn;
    assign host_off_we = host_we_w[0];
    assign host_fs_we  = host_we_w[1];
endmodule

// File: rtl/cms_checker.sv
module cms_checker
    import cms_pkg::*;
#(
    parameter int RATE_W = 4,
    parameter int GAIN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic [2:0]        mode_in,
    input logic [RATE_W-1:0] rate_in,
    input logic [GAIN_W-1:0] gain_in,
    input logic              conv_tick,
    input logic [2:0]        mode_out,
    input logic              rdy,
    input logic              result_we,
    input logic              cal_off_wr,
    input logic              cal_fs_wr,
    input logic              fs_factory,
    input logic              host_off_we,
    input logic              host_fs_we
);
    localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};

    // R6
    pd_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == 3'd3) |-> rdy);
    // R4
    result_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_we |-> !rdy);
    // R8
    cal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_off_wr || cal_fs_wr) |-> (mode_out == 3'd2));
    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_off_wr, cal_fs_wr, result_we}));
    // R11
    host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_off_we || host_fs_we) |-> (mode_out == 3'd2 || mode_out == 3'd3));
    // R10
    bad_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_in == 3'd5 && gain_in == GMAX && rate_in != '0)
        |=> (mode_out == $past(mode_out)));
    // R9
    factory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_factory |-> cal_fs_wr);
    // R6
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == 3'd2 && conv_tick && !mode_wr) |=> !result_we);
endmodule

bind conv_mode_seq cms_checker #(.RATE_W(RATE_W), .GAIN_W(GAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .rate_in(rate_in), .gain_in(gain_in), .conv_tick(conv_tick),
    .mode_out(mode_out), .rdy(rdy), .result_we(result_we),
    .cal_off_wr(cal_off_wr), .cal_fs_wr(cal_fs_wr), .fs_factory(fs_factory),
    .host_off_we(host_off_we), .host_fs_we(host_fs_we)
);

// File: tb/conv_mode_seq_bench.sv
module conv_mode_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 0, cfg_wr = 0, ref_int = 0, conv_tick = 0, clamp_in = 0;
    logic data_rd = 0, host_off_wr = 0, host_fs_wr = 0;
    logic [2:0] mode_in = 0, gain_in = 0;
    logic [3:0] rate_in = 4'd1;
    logic [2:0] mode_out;
    logic [3:0] rate_sel;
    logic rdy, err, result_we, cal_off_wr, cal_fs_wr, fs_factory;
    logic mod_rst, pwr_dn, host_off_we, host_fs_we;
    int n_total = 0, n_pass = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    conv_mode_seq u_conv_mode_seq (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .rate_in(rate_in), .cfg_wr(cfg_wr), .gain_in(gain_in), .ref_int(ref_int),
        .conv_tick(conv_tick), .clamp_in(clamp_in), .data_rd(data_rd),
        .host_off_wr(host_off_wr), .host_fs_wr(host_fs_wr),
        .mode_out(mode_out), .rate_sel(rate_sel), .rdy(rdy), .err(err),
        .result_we(result_we), .cal_off_wr(cal_off_wr), .cal_fs_wr(cal_fs_wr),
        .fs_factory(fs_factory), .mod_rst(mod_rst), .pwr_dn(pwr_dn),
        .host_off_we(host_off_we), .host_fs_we(host_fs_we)
    );

    // {mode, gain, ref_int, ticks, kind}; kind 1 offset, 2 full-scale, 3 factory
    localparam logic [11:0] VEC [8] = '{
        {3'd4, 3'd3, 1'b0, 3'd2, 2'd1},
        {3'd5, 3'd0, 1'b0, 3'd2, 2'd2},
        {3'd5, 3'd0, 1'b1, 3'd0, 2'd3},
        {3'd5, 3'd3, 1'b0, 3'd4, 2'd2},
        {3'd5, 3'd5, 1'b1, 3'd4, 2'd2},
        {3'd6, 3'd7, 1'b0, 3'd2, 2'd1},
        {3'd7, 3'd7, 1'b1, 3'd2, 2'd2},
        {3'd4, 3'd0, 1'b1, 3'd2, 2'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act == exp) n_pass++;
        else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic clr();
        mode_wr = 0; cfg_wr = 0; conv_tick = 0; clamp_in = 0;
        data_rd = 0; host_off_wr = 0; host_fs_wr = 0;
    endtask

    task automatic wr_mode(input logic [2:0] m, input logic [3:0] r);
        mode_in = m; rate_in = r; mode_wr = 1;
        cyc();
    endtask

    task automatic tick();
        conv_tick = 1;
        cyc();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_pass, n_total);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_total++;
            $display("FAIL watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        // R1 reset state
        chk("R1 mode", mode_out, 0);
        chk("R1 rdy", rdy, 1);
        chk("R1 err", err, 0);
        chk("R1 rate", rate_sel, 10);
        chk("R1 pwr_dn", pwr_dn, 0);
        chk("R1 mod_rst", mod_rst, 0);

        // R4 continuous: first result discarded, then every tick
        tick(); chk("R4 first tick no result", result_we, 0); chk("R4 rdy high", rdy, 1); clr();
        tick(); chk("R4 second tick result", result_we, 1); chk("R4 rdy low", rdy, 0); clr();
        data_rd = 1; cyc(); chk("R4 read sets rdy", rdy, 1); clr();
        tick(); chk("R4 next period result", result_we, 1); clr();

        // R7 clamp sets err
        clamp_in = 1; tick(); chk("R7 err set", err, 1); clr();
        // R11 host write blocked in continuous
        host_off_wr = 1; cyc(); chk("R11 host off blocked", host_off_we, 0); clr();

        // R2 rate 0 write ignored
        wr_mode(3'd1, 4'd0); clr();
        chk("R2 rate0 mode kept", mode_out, 0);
        chk("R2 rate0 rate kept", rate_sel, 10);
        chk("R2 rate0 no restart", mod_rst, 0);
        chk("R7 rejected write keeps err", err, 1);
        // R2 / R7 accepted write
        wr_mode(3'd0, 4'd3); clr();
        chk("R7 err cleared", err, 0);
        chk("R2 rdy", rdy, 1);
        chk("R2 mod_rst pulse", mod_rst, 1);
        chk("R2 rate", rate_sel, 3);
        cyc(); chk("R2 mod_rst one cycle", mod_rst, 0);

        // R3 cfg write restarts
        tick(); clr();
        tick(); clr();
        cfg_wr = 1; cyc(); clr();
        chk("R3 rdy", rdy, 1); chk("R3 mod_rst", mod_rst, 1);
        tick(); chk("R3 first tick no result", result_we, 0); clr();
        tick(); chk("R3 second tick result", result_we, 1); clr();

        // R5 single
        wr_mode(3'd1, 4'd5); clr();
        chk("R5 powered", pwr_dn, 0);
        tick(); chk("R5 first tick", result_we, 0); clr();
        tick(); chk("R5 result", result_we, 1); chk("R5 rdy", rdy, 0); clr();
        chk("R5 power down", pwr_dn, 1);
        tick(); chk("R5 no more result", result_we, 0); chk("R5 rdy held", rdy, 0); clr();
        data_rd = 1; cyc(); chk("R5 read", rdy, 1); clr();

        // R6 idle and power-down
        wr_mode(3'd2, 4'd5); clr();
        cyc(); chk("R6 idle mod_rst", mod_rst, 1);
        tick(); chk("R6 idle tick ignored", result_we, 0); clr();
        host_fs_wr = 1; cyc(); chk("R11 host fs in idle", host_fs_we, 1); clr();
        wr_mode(3'd3, 4'd5); clr();
        chk("R6 pd pwr_dn", pwr_dn, 1); chk("R6 pd rdy", rdy, 1);
        host_off_wr = 1; cyc(); chk("R11 host off in pd", host_off_we, 1); clr();

        // R8 / R9 calibration table
        for (int i = 0; i < 8; i++) begin
            logic [2:0] vm, vg, vt; logic vr; logic [1:0] vk;
            {vm, vg, vr, vt, vk} = VEC[i];
            wr_mode(3'd2, 4'd5); clr();
            gain_in = vg; ref_int = vr;
            wr_mode(vm, 4'd5); clr();
            if (vk == 2'd3) begin
                chk("R9 factory strobe", {fs_factory, cal_fs_wr}, 3);
                chk("R9 idle", mode_out, 2);
                chk("R9 rdy low", rdy, 0);
            end else begin
                chk("R8 cal running rdy", rdy, 1);
                chk("R8 cal mode", mode_out, vm);
                for (int t = 1; t <= vt; t++) begin
                    tick(); clr();
                    if (t < vt) begin
                        chk("R8 early strobe", {cal_off_wr, cal_fs_wr}, 0);
                    end else begin
                        chk("R8 strobe kind", {cal_fs_wr, cal_off_wr}, vk);
                        chk("R8 ends idle", mode_out, 2);
                        chk("R8 rdy low", rdy, 0);
                    end
                end
            end
        end

        // R10 illegal full-scale cal at gain code 7
        gain_in = 3'd7; ref_int = 0;
        wr_mode(3'd5, 4'd5); clr();
        chk("R10 mode kept", mode_out, 2);
        chk("R10 rdy high", rdy, 1);
        tick(); chk("R10 no strobe", cal_fs_wr, 0); clr();

        done = 1;
        summary();
        $finish;
    end
endmodule